// File: doc/BRIEF.md
# Transponder Read-Out Sequencer

This block decides, one field clock at a time, which memory bit a passive transponder sends next. It runs the whole read-out sequence. After reset it stays quiet while the configuration block loads. It then steps through the user blocks bit by bit, adds the optional synchronisation terminators, and announces each bit boundary to the line encoder that follows it. Memory is read through a simple combinational port. The block gives a block index and a bit index, and the memory returns one bit. The configuration fields arrive as plain inputs and are copied into an internal mode register each time a new block starts.

The controller is one state machine with six states:
- `ST_LOAD` waits out the configuration load.
- `ST_AOR_WAIT` holds the output quiet until a wake-up arrives.
- `ST_BTERM` sends a two-period block terminator.
- `ST_DATA` sends bits 1 to 32 of the current block.
- `ST_STERM` sends the four-period sequence terminator.
- `ST_SILENT` is entered on a stop request and is left only by reset.

The transitions are:
- load done goes to wait (request mode) or to a block start.
- wake goes from wait to a block start.
- a terminator that ends goes to data.
- the end of a block goes to the next block start, to the sequence terminator, or back to the first block.
- the end of the sequence terminator goes back to the first block.
- restart goes from any sending state to the given block.
- stop goes from any state to silent.

A block start goes to `ST_BTERM` when block terminators are enabled, and to `ST_DATA` when they are not.

Top module: `rdout_seq`

## Requirements
- R1: After reset release, `mod_en_o` and `bit_stb_o` stay low for 255 field clocks. The first bit strobe comes in the 256th clock, unless request mode (`cfg_aor`=1) is set.
- R2: Blocks are sent from block 1 up to `cfg_lastblk`, and then the sequence wraps back to block 1. Each block sends bits 1 to 32 in rising order. Bit index 0, the lock bit, is never put on `mem_bit_o`.
- R3: When `cfg_lastblk` is 0, only block 0 (bits 1 to 32) is sent, over and over, and no sequence terminator is ever added.
- R4: The bit period follows `cfg_rate`. Codes 0 to 7 give 8, 16, 32, 40, 50, 64, 100 and 128 field clocks per bit.
- R5: When `cfg_bterm_en`=1, every block is preceded by one bit period of data 1 and then one bit period of data 0.
- R6: When `cfg_sterm_en`=1 and `cfg_lastblk`≠0, the data pattern 1,0,1,0 (one period each) follows the last block.
- R7: At each block start, the mode inputs are copied into the mode register. `mode_ld_o` pulses together with that block's first bit strobe. A mode input that changes in the middle of a block takes effect only at the next block start.
- R8: In request mode, no modulation happens after the load until `wake_i` is seen. The first strobe then comes in the next clock, and it starts the first block.
- R9: A `restart_i` pulse in a sending state moves the sequence, in the next clock, to block `restart_blk`. That block is preceded by a block terminator if either terminator enable is set. It is sent with the old mode and without `mode_ld_o`. The mode is refreshed again at the following block start.
- R10: A `stop_i` pulse silences the output from the next clock until reset. `wake_i` and `restart_i` are ignored after that.
- R11: Whenever `mod_en_o` is low, `data_o` and `bit_stb_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fc | input | 1 | Field clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| cfg_rate | input | 3 | Bit period code from the configuration block |
| cfg_lastblk | input | BLK_AW | Last block number to send |
| cfg_bterm_en | input | 1 | Block terminator enable |
| cfg_sterm_en | input | 1 | Sequence terminator enable |
| cfg_aor | input | 1 | Request mode: wait for wake-up after the load |
| wake_i | input | 1 | Wake-up indication (one-clock pulse) |
| stop_i | input | 1 | Silence request (one-clock pulse) |
| restart_i | input | 1 | Restart request after programming (one-clock pulse) |
| restart_blk | input | BLK_AW | Block at which a restart resumes |
| mem_blk_o | output | BLK_AW | Memory read block index |
| mem_bit_o | output | BIT_W | Memory read bit index |
| mem_rd_i | input | 1 | Memory read data |
| mod_en_o | output | 1 | Modulation active |
| data_o | output | 1 | NRZ bit to the line encoder |
| bit_stb_o | output | 1 | First field clock of each bit period |
| mode_ld_o | output | 1 | Mode register was refreshed at this block start |

## Verification
The hardest case to reach is the restart path. There, the mode inputs have already changed, but the resumed block must still go out at the old rate and with no refresh strobe, and the new rate must appear only at the block after it. The bench streams part of block 1 at the fastest rate. In a single clock it then changes the rate code and pulses restart toward a later block. It checks every gap between strobes across the terminator, the resumed block and the next block. A similar step changes the rate in the middle of a block without a restart. The sweep over all last-block values and terminator combinations covers the wrap-around and the rule that drops the sequence terminator when the last-block value is zero.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_AOR_WAIT,
        ST_BTERM,
        ST_DATA,
        ST_STERM,
        ST_SILENT
    } seq_state_e;

    localparam int PER_W = 8;

    // field clocks per bit for each rate code
    function automatic logic [PER_W-1:0] period_of(input logic [2:0] code);
        logic [PER_W-1:0] p;
        unique case (code)
            3'd0: p = 8'd8;
            3'd1: p = 8'd16;
            3'd2: p = 8'd32;
            3'd3: p = 8'd40;
            3'd4: p = 8'd50;
            3'd5: p = 8'd64;
            3'd6: p = 8'd100;
            default: p = 8'd128;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rdseq_bit_timer.sv
module rdseq_bit_timer #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PER_W-1:0] period,
    output logic             at_first,
    output logic             at_last
);
    logic [PER_W-1:0] tmr_q;

    assign at_first = (tmr_q == '0);
    assign at_last  = (tmr_q == period - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tmr_q <= '0;
        else if (clr)     tmr_q <= '0;
        else if (at_last) tmr_q <= '0;
        else              tmr_q <= tmr_q + 1'b1;
    end
endmodule

// File: rtl/rdseq_load_cnt.sv
module rdseq_load_cnt #(
    parameter int CFG_CLKS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    localparam int LD_W = (CFG_CLKS > 1) ? $clog2(CFG_CLKS) : 1;

    logic [LD_W-1:0] cnt_q;

    assign done = en && (cnt_q == LD_W'(CFG_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (en && !done)    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rdout_seq.sv
module rdout_seq
    import rdseq_pkg::*;
#(
    parameter int BLK_AW   = 3,
    parameter int BLK_BITS = 32,
    parameter int CFG_CLKS = 256,
    localparam int BIT_W   = $clog2(BLK_BITS + 1)
) (
    input  logic              clk_fc,
    input  logic              rst_n,
    input  logic [2:0]        cfg_rate,
    input  logic [BLK_AW-1:0] cfg_lastblk,
    input  logic              cfg_bterm_en,
    input  logic              cfg_sterm_en,
    input  logic              cfg_aor,
    input  logic              wake_i,
    input  logic              stop_i,
    input  logic              restart_i,
    input  logic [BLK_AW-1:0] restart_blk,
    output logic [BLK_AW-1:0] mem_blk_o,
    output logic [BIT_W-1:0]  mem_bit_o,
    input  logic              mem_rd_i,
    output logic              mod_en_o,
    output logic              data_o,
    output logic              bit_stb_o,
    output logic              mode_ld_o
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BLK_BITS);

    seq_state_e        state_q, state_d;
    logic [BLK_AW-1:0] blk_q, blk_d;
    logic [BIT_W-1:0]  cnt_q, cnt_d;
    logic [2:0]        rate_q;
    logic [BLK_AW-1:0] maxb_q;
    logic              bten_q, sten_q, ld_q;
    logic              cap, tclr, active;
    logic              t_first, t_last, load_done;
    logic [BLK_AW-1:0] first_new, first_old;

    assign active    = (state_q == ST_BTERM) || (state_q == ST_DATA) || (state_q == ST_STERM);
    assign first_new = (cfg_lastblk == '0) ? '0 : BLK_AW'(1);
    assign first_old = (maxb_q == '0) ? '0 : BLK_AW'(1);

    rdseq_load_cnt #(.CFG_CLKS(CFG_CLKS)) i_load (
        .clk  (clk_fc),
        .rst_n(rst_n),
        .en   (state_q == ST_LOAD),
        .done (load_done)
    );

    rdseq_bit_timer #(.PER_W(PER_W)) i_timer (
        .clk     (clk_fc),
        .rst_n   (rst_n),
        .clr     (tclr || !active),
        .period  (period_of(rate_q)),
        .at_first(t_first),
        .at_last (t_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        blk_d   = blk_q;
        cnt_d   = cnt_q;
        cap     = 1'b0;
        tclr    = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                if (load_done) begin
                    if (cfg_aor) begin
                        state_d = ST_AOR_WAIT;
                    end else begin
                        cap = 1'b1;
                        blk_d = first_new;
                    end
                end
            end
            ST_AOR_WAIT: begin
                if (wake_i) begin
                    cap = 1'b1;
                    blk_d = first_new;
                end
            end
            ST_BTERM: begin
                if (t_last) begin
                    if (cnt_q == BIT_W'(1)) begin
                        state_d = ST_DATA;
                        cnt_d   = BIT_W'(1);
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (t_last) begin
                    if (cnt_q == LAST_BIT) begin
                        if (blk_q >= maxb_q) begin
                            if (sten_q && (maxb_q != '0)) begin
                                state_d = ST_STERM;
                                cnt_d   = '0;
                            end else begin
                                cap = 1'b1;
                                blk_d = first_old;
                            end
                        end else begin
                            cap = 1'b1;
                            blk_d = blk_q + 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_STERM: begin
                if (t_last) begin
                    if (cnt_q == BIT_W'(3)) begin
                        cap = 1'b1;
                        blk_d = first_old;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_SILENT: begin
            end
        endcase

        // block start with mode refresh
        if (cap) begin
            tclr    = 1'b1;
            state_d = cfg_bterm_en ? ST_BTERM : ST_DATA;
            cnt_d   = cfg_bterm_en ? '0 : BIT_W'(1);
        end

        // resume after programming: old mode, no refresh
        if (restart_i && active) begin
            cap     = 1'b0;
            tclr    = 1'b1;
            blk_d   = restart_blk;
            state_d = (bten_q || sten_q) ? ST_BTERM : ST_DATA;
            cnt_d   = (bten_q || sten_q) ? '0 : BIT_W'(1);
        end

        if (stop_i) begin
            cap     = 1'b0;
            state_d = ST_SILENT;
        end
    end

    // state register
    always_ff @(posedge clk_fc or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            blk_q   <= '0;
            cnt_q   <= '0;
            rate_q  <= '0;
            maxb_q  <= '0;
            bten_q  <= 1'b0;
            sten_q  <= 1'b0;
            ld_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            blk_q   <= blk_d;
            cnt_q   <= cnt_d;
            ld_q    <= cap;
            if (cap) begin
                rate_q <= cfg_rate;
                maxb_q <= cfg_lastblk;
                bten_q <= cfg_bterm_en;
                sten_q <= cfg_sterm_en;
            end
        end
    end

    // outputs
    always_comb begin
        mod_en_o  = active;
        bit_stb_o = active && t_first;
        mode_ld_o = ld_q;
        mem_blk_o = blk_q;
        mem_bit_o = (state_q == ST_DATA) ? cnt_q : BIT_W'(1);
        unique case (state_q)
            ST_DATA:            data_o = mem_rd_i;
            ST_BTERM, ST_STERM: data_o = ~cnt_q[0];
            default:            data_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rdout_seq_chk.sv
module rdout_seq_chk #(
    parameter int BLK_BITS = 32,
    parameter int BIT_W    = 6
) (
    input logic             clk_fc,
    input logic             rst_n,
    input logic             stop_i,
    input logic [BIT_W-1:0] mem_bit_o,
    input logic             mod_en_o,
    input logic             data_o,
    input logic             bit_stb_o,
    input logic             mode_ld_o
);
    logic seen_stop_q;

    always_ff @(posedge clk_fc or negedge rst_n) begin
        if (!rst_n)      seen_stop_q <= 1'b0;
        else if (stop_i) seen_stop_q <= 1'b1;
    end

    AST_START_ON_BOUNDARY: assert property (@(posedge clk_fc) disable iff (!rst_n)
        $rose(mod_en_o) |-> bit_stb_o);                                  // R1
    AST_NO_LOCK_BIT: assert property (@(posedge clk_fc) disable iff (!rst_n)
        mod_en_o |-> (mem_bit_o != '0) && (mem_bit_o <= BIT_W'(BLK_BITS))); // R2
    AST_LD_ON_STROBE: assert property (@(posedge clk_fc) disable iff (!rst_n)
        mode_ld_o |-> bit_stb_o);                                        // R7
    AST_STOP_NEXT: assert property (@(posedge clk_fc) disable iff (!rst_n)
        stop_i |=> !mod_en_o);                                           // R10
    AST_STOP_STICKY: assert property (@(posedge clk_fc) disable iff (!rst_n)
        seen_stop_q |-> !mod_en_o);                                      // R10
    AST_QUIET_OUTPUTS: assert property (@(posedge clk_fc) disable iff (!rst_n)
        !mod_en_o |-> !bit_stb_o && !data_o);                            // R11
endmodule

bind rdout_seq rdout_seq_chk #(.BLK_BITS(BLK_BITS), .BIT_W(BIT_W)) i_chk (
    .clk_fc   (clk_fc),
    .rst_n    (rst_n),
    .stop_i   (stop_i),
    .mem_bit_o(mem_bit_o),
    .mod_en_o (mod_en_o),
    .data_o   (data_o),
    .bit_stb_o(bit_stb_o),
    .mode_ld_o(mode_ld_o)
);

// File: tb/test_rdout_seq.sv
`timescale 1ns/1ps
module test_rdout_seq;
    localparam int BLK_AW = 3;
    localparam int BIT_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cfg_rate = '0;
    logic [BLK_AW-1:0] cfg_lastblk = '0;
    logic              cfg_bterm_en = 1'b0, cfg_sterm_en = 1'b0, cfg_aor = 1'b0;
    logic              wake_i = 1'b0, stop_i = 1'b0, restart_i = 1'b0;
    logic [BLK_AW-1:0] restart_blk = '0;
    logic [BLK_AW-1:0] mem_blk;
    logic [BIT_W-1:0]  mem_bit;
    logic              mem_rd;
    logic              mod_en, data, bit_stb, mode_ld;

    int tests = 0;
    int fails = 0;
    int q_d[$];
    int q_p[$];
    int q_l[$];

    always #4 clk = ~clk;

    function automatic int memf(input int b, input int i);
        return ((b * 29 + i * i * 3 + i) >> 2) & 1;
    endfunction

    function automatic int per(input int code);
        case (code)
            0: return 8;   1: return 16;  2: return 32;  3: return 40;
            4: return 50;  5: return 64;  6: return 100; default: return 128;
        endcase
    endfunction

    assign mem_rd = memf(int'(mem_blk), int'(mem_bit)) != 0;

    rdout_seq i_rdout_seq (
        .clk_fc(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_lastblk(cfg_lastblk),
        .cfg_bterm_en(cfg_bterm_en), .cfg_sterm_en(cfg_sterm_en), .cfg_aor(cfg_aor),
        .wake_i(wake_i), .stop_i(stop_i), .restart_i(restart_i), .restart_blk(restart_blk),
        .mem_blk_o(mem_blk), .mem_bit_o(mem_bit), .mem_rd_i(mem_rd),
        .mod_en_o(mod_en), .data_o(data), .bit_stb_o(bit_stb), .mode_ld_o(mode_ld)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input int d, input int p, input int l);
        q_d.push_back(d); q_p.push_back(p); q_l.push_back(l);
    endtask

    task automatic clearq();
        q_d.delete(); q_p.delete(); q_l.delete();
    endtask

    task automatic push_block(input int b, input int p, input int bt, input int ld);
        if (bt != 0) begin
            push(1, p, ld); push(0, p, 0);
        end
        for (int i = 1; i <= 32; i++) push(memf(b, i), p, (bt == 0 && i == 1) ? ld : 0);
    endtask

    task automatic push_round(input int maxb, input int bt, input int st, input int p);
        int first;
        first = (maxb == 0) ? 0 : 1;
        for (int b = first; b <= maxb; b++) push_block(b, p, bt, 1);
        if (st != 0 && maxb != 0) begin
            push(1, p, 0); push(0, p, 0); push(1, p, 0); push(0, p, 0);
        end
    endtask

    // walk the expected units: data, spacing and refresh strobe
    task automatic collect(input bit imm, input string tag);
        int idx, gap;
        bit first;
        idx = 0; gap = 0; first = 1'b1;
        while (idx < q_d.size()) begin
            @(negedge clk);
            gap++;
            if (first && imm) chk(bit_stb === 1'b1, {tag, " first strobe at once"}, int'(bit_stb), 1);
            first = 1'b0;
            if (bit_stb === 1'b1) begin
                if (idx > 0) chk(gap == q_p[idx-1], {tag, " R4 bit period"}, gap, q_p[idx-1]);
                chk(int'(data) == q_d[idx], {tag, " R2 data bit"}, int'(data), q_d[idx]);
                chk(int'(mode_ld) == q_l[idx], {tag, " R7 refresh strobe"}, int'(mode_ld), q_l[idx]);
                gap = 0;
                idx++;
            end
        end
        clearq();
    endtask

    task automatic start(input int rate, input int maxb, input int bt, input int st, input int aor);
        int bad;
        cfg_rate = 3'(rate); cfg_lastblk = 3'(maxb);
        cfg_bterm_en = bt[0]; cfg_sterm_en = st[0]; cfg_aor = aor[0];
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bad = 0;
        for (int k = 1; k <= 255; k++) begin
            @(negedge clk);
            if (mod_en || bit_stb || data) bad++;
        end
        chk(bad == 0, "R1 quiet during load (R11 outputs low)", bad, 0);
    endtask

    initial begin
        #(8ns * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // sweep of last block and terminator enables (R2 R3 R5 R6)
        for (int m = 0; m <= 7; m++)
            for (int bt = 0; bt <= 1; bt++)
                for (int st = 0; st <= 1; st++) begin
                    start(0, m, bt, st, 0);
                    push_round(m, bt, st, 8);
                    push_round(m, bt, st, 8);
                    collect(1'b1, (m == 0) ? "R3 sweep" : ((st != 0) ? "R6 sweep" : "R5 sweep"));
                end

        // every rate code (R4)
        for (int r = 0; r <= 7; r++) begin
            start(r, 1, 1, 1, 0);
            push_round(1, 1, 1, per(r));
            push(1, per(r), 1);
            collect(1'b1, "R4 rate");
        end

        // rate change in the middle of a block (R7)
        start(0, 1, 0, 0, 0);
        for (int i = 1; i <= 10; i++) push(memf(1, i), 8, (i == 1) ? 1 : 0);
        collect(1'b1, "R7 part A");
        cfg_rate = 3'd1;
        for (int i = 11; i <= 32; i++) push(memf(1, i), 8, 0);
        push_block(1, 16, 0, 1);
        collect(1'b0, "R7 part B");

        // restart with changed mode (R9)
        start(0, 3, 0, 1, 0);
        for (int i = 1; i <= 10; i++) push(memf(1, i), 8, (i == 1) ? 1 : 0);
        collect(1'b1, "R9 before");
        restart_blk = 3'd2; cfg_rate = 3'd1; restart_i = 1'b1;
        @(posedge clk); #1 restart_i = 1'b0;
        push_block(2, 8, 1, 0);
        push_block(3, 16, 0, 1);
        push(1, 16, 0); push(0, 16, 0); push(1, 16, 0); push(0, 16, 0);
        push_block(1, 16, 0, 1);
        collect(1'b1, "R9 restart");

        // request mode waits for wake (R8)
        begin
            int bad;
            start(0, 2, 1, 0, 1);
            bad = 0;
            repeat (400) begin
                @(negedge clk);
                if (mod_en || bit_stb) bad++;
            end
            chk(bad == 0, "R8 no modulation before wake", bad, 0);
            wake_i = 1'b1;
            @(posedge clk); #1 wake_i = 1'b0;
            push_round(2, 1, 0, 8);
            collect(1'b1, "R8 after wake");
        end

        // stop is permanent (R10, R11)
        begin
            int bad;
            start(0, 2, 1, 1, 0);
            push_block(1, 8, 1, 1);
            collect(1'b1, "R10 before stop");
            stop_i = 1'b1;
            @(posedge clk); #1 stop_i = 1'b0;
            bad = 0;
            for (int k = 0; k < 600; k++) begin
                if (k == 100) begin restart_i = 1'b1; restart_blk = 3'd1; end
                if (k == 101) restart_i = 1'b0;
                if (k == 300) wake_i = 1'b1;
                if (k == 301) wake_i = 1'b0;
                @(negedge clk);
                if (mod_en || bit_stb || data) bad++;
            end
            chk(bad == 0, "R10 silent after stop, R11 outputs low", bad, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule